// File: doc/BRIEF.md
# Crypto Register Access-Level Tracker

This block owns a bank of eight 128-bit crypto registers and keeps an access label for each one. A label is either *open*, which means the register may be copied back to data memory, or *confidential*, which means its value must never leave the bank. Commands can do the following: load a register from memory, fetch a hardware secret, encrypt, signature-encrypt, compare, read back, clear the bank, or do nothing. The cipher itself lives outside the block. For each encrypt, the block sends a key/data pair to the cipher and writes the returned result into the destination register. It also gives that register the label derived from the operands.

Labels follow data through the cipher. If either operand of a plain encrypt is confidential, the result is confidential too. The only exception is the signature-encrypt, which encrypts the auth-hash register (index 6) under a key register. This is the only path that produces an open result from a confidential key. A read of a confidential register returns zero and raises a sticky violation flag. A compare reports one pass/fail bit and never exposes its operands.

All three data paths use valid/ready: the command port, the cipher request/response pair and the read-back port. A transfer happens on a clock edge where both valid and ready are high. While valid is held with ready low, the producer keeps its payload stable. The block accepts one command at a time and holds `cmd_ready` low until a cipher operation or a read completes.

Top module: `keyreg_guard`

## Requirements
- R1: After reset every register holds zero and every label is open (`conf_map` all zero), `cmd_ready` is 1, `viol_flag` is 0 and no request, read or compare output is valid.
- R2: Command code 0 (load) writes `cmd_wdata` into register `cmd_dst` and marks it open.
- R3: Command code 1 (secret) drives `sec_idx` from `cmd_sec` and writes `sec_data` into `cmd_dst`. Secret index 0 gives an open label and every other index gives a confidential one.
- R4: Command code 2 (encrypt) presents `cip_key` = register `cmd_key` and `cip_data` = register `cmd_src`, and holds both stable until `cip_req_ready`. The response is written to `cmd_dst`, which becomes confidential if either operand was confidential and open otherwise.
- R5: Command code 3 (signature-encrypt) presents register `cmd_key` as key and register 6 as data. Its destination is always open, even when the key was confidential.
- R6: Command code 4 (read) of an open register presents its value on `rd_data` with `rd_valid` high. The value is held unchanged until `rd_ready` is seen.
- R7: A read of a confidential register presents zero and sets `viol_flag` one cycle after acceptance. The flag stays set until `viol_clr` is high, and a new violation in the same cycle wins over the clear.
- R8: Command code 5 (compare) raises `cmp_valid` for exactly one cycle, one cycle after acceptance. `cmp_pass` is 1 only if registers `cmd_dst` and `cmd_src` are equal, and no register or label changes.
- R9: Command code 6 (clear) zeroes every register and marks every label open.
- R10: While an encrypt or read is in flight, `cmd_ready` is 0 and a command offered on the port has no effect.
- R11: Command code 7 (no-op) is accepted and changes no register, label or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted this edge if valid |
| cmd_op | input | 3 | Command code |
| cmd_dst | input | 3 | Destination / first compare register |
| cmd_src | input | 3 | Data source / read / second compare register |
| cmd_key | input | 3 | Key register for encrypts |
| cmd_sec | input | 6 | Hardware secret index |
| cmd_wdata | input | 128 | Memory data for loads |
| sec_idx | output | 6 | Secret index to the secret store |
| sec_data | input | 128 | Secret value returned by the store |
| cip_req_valid | output | 1 | Cipher request valid |
| cip_req_ready | input | 1 | Cipher takes the request |
| cip_key | output | 128 | Key operand |
| cip_data | output | 128 | Data operand |
| cip_rsp_valid | input | 1 | Cipher result valid |
| cip_rsp_ready | output | 1 | Block waits for a result |
| cip_rsp_data | input | 128 | Cipher result |
| rd_valid | output | 1 | Read-back data valid |
| rd_ready | input | 1 | Memory side takes the data |
| rd_data | output | 128 | Read-back value, zero when blocked |
| cmp_valid | output | 1 | Compare result strobe |
| cmp_pass | output | 1 | Compare operands equal |
| viol_flag | output | 1 | Sticky access violation |
| viol_clr | input | 1 | Clears the violation flag |
| conf_map | output | 8 | Per-register label, 1 = confidential |

## Verification
On every cycle, the assertions check the label outcome of loads, secret fetches and clears. They also check that read data and cipher operands stay stable under back-pressure, that a blocked read sets the sticky flag with zero data, that the compare strobe appears, and that the port stays closed while busy. Only the bench scenarios can show that labels propagate through chained encrypts and that the signature-encrypt downgrade reads back the right value. They also cover the full authentication sequence ending in a passing compare, and they show that commands offered while busy leave no trace in register contents.

// File: rtl/kg_pkg.sv
package kg_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_SECRET = 3'd1,
    OP_ENC    = 3'd2,
    OP_SIGENC = 3'd3,
    OP_READ   = 3'd4,
    OP_CMP    = 3'd5,
    OP_CLEAR  = 3'd6,
    OP_NOP    = 3'd7
  } kg_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_RD
  } kg_state_e;

  // external level codes: confidential and open
  localparam logic [7:0] LVL_CONF = 8'h10;
  localparam logic [7:0] LVL_OPEN = 8'h13;
endpackage

// File: rtl/kg_regbank.sv
module kg_regbank #(
  parameter int NREG = 8,
  parameter int W    = 128,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [W-1:0]    wr_data,
  input  logic            wr_conf,
  input  logic            clr_all,
  output logic [W-1:0]    vals [NREG],
  output logic [NREG-1:0] conf
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) begin
        vals[g] <= '0;
        conf[g] <= 1'b0;
      end else if (hit) begin
        vals[g] <= wr_data;
        conf[g] <= wr_conf;
      end
    end
  end
endmodule

// File: rtl/kg_label.sv
module kg_label import kg_pkg::*; #(
  parameter int SW          = 6,
  parameter int OPEN_SECRET = 0
) (
  input  kg_op_e        op,
  input  logic [SW-1:0] sec,
  input  logic          key_conf,
  input  logic          src_conf,
  output logic          out_conf
);
  always_comb begin
    unique case (op)
      OP_SECRET: out_conf = (sec != SW'(OPEN_SECRET));
      OP_ENC:    out_conf = key_conf | src_conf;
      // signature-encrypt is the single downgrade path
      OP_SIGENC: out_conf = 1'b0;
      default:   out_conf = 1'b0;
    endcase
  end
endmodule

// File: rtl/kg_ctrl.sv
module kg_ctrl import kg_pkg::*; #(
  parameter int NREG     = 8,
  parameter int W        = 128,
  parameter int AUTH_IDX = 6,
  localparam int IW      = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  kg_op_e          op,
  input  logic [IW-1:0]   cmd_dst,
  input  logic [IW-1:0]   cmd_src,
  input  logic [IW-1:0]   cmd_key,
  input  logic [W-1:0]    cmd_wdata,
  input  logic [W-1:0]    sec_data,
  input  logic [W-1:0]    vals [NREG],
  input  logic [NREG-1:0] conf,
  input  logic            lbl_conf,
  output logic            wr_en,
  output logic [IW-1:0]   wr_idx,
  output logic [W-1:0]    wr_data,
  output logic            wr_conf,
  output logic            clr_all,
  output logic            cip_req_valid,
  input  logic            cip_req_ready,
  output logic [W-1:0]    cip_key,
  output logic [W-1:0]    cip_data,
  input  logic            cip_rsp_valid,
  output logic            cip_rsp_ready,
  input  logic [W-1:0]    cip_rsp_data,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [W-1:0]    rd_data,
  output logic            cmp_valid,
  output logic            cmp_pass,
  output logic            viol_flag,
  input  logic            viol_clr
);
  kg_state_e       state;
  logic [IW-1:0]   dst_q;
  logic            conf_q;
  logic [W-1:0]    key_q, dat_q, rd_q;
  logic            accept, blocked;

  assign cmd_ready     = (state == ST_IDLE);
  assign accept        = cmd_valid && cmd_ready;
  assign blocked       = accept && (op == OP_READ) && conf[cmd_src];
  assign cip_req_valid = (state == ST_REQ);
  assign cip_rsp_ready = (state == ST_WAIT);
  assign rd_valid      = (state == ST_RD);
  assign cip_key       = key_q;
  assign cip_data      = dat_q;
  assign rd_data       = rd_q;
  assign clr_all       = accept && (op == OP_CLEAR);

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = cmd_dst;
    wr_data = cmd_wdata;
    wr_conf = lbl_conf;
    if (accept && op == OP_LOAD) begin
      wr_en = 1'b1;
    end else if (accept && op == OP_SECRET) begin
      wr_en   = 1'b1;
      wr_data = sec_data;
    end else if (cip_rsp_ready && cip_rsp_valid) begin
      wr_en   = 1'b1;
      wr_idx  = dst_q;
      wr_data = cip_rsp_data;
      wr_conf = conf_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dst_q     <= '0;
      conf_q    <= 1'b0;
      key_q     <= '0;
      dat_q     <= '0;
      rd_q      <= '0;
      cmp_valid <= 1'b0;
      cmp_pass  <= 1'b0;
      viol_flag <= 1'b0;
    end else begin
      cmp_valid <= accept && (op == OP_CMP);
      cmp_pass  <= accept && (op == OP_CMP) && (vals[cmd_dst] == vals[cmd_src]);
      if (blocked)       viol_flag <= 1'b1;
      else if (viol_clr) viol_flag <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          if (op == OP_ENC || op == OP_SIGENC) begin
            dst_q  <= cmd_dst;
            conf_q <= lbl_conf;
            key_q  <= vals[cmd_key];
            dat_q  <= (op == OP_SIGENC) ? vals[AUTH_IDX] : vals[cmd_src];
            state  <= ST_REQ;
          end else if (op == OP_READ) begin
            rd_q  <= conf[cmd_src] ? '0 : vals[cmd_src];
            state <= ST_RD;
          end
        end
        ST_REQ:  if (cip_req_ready) state <= ST_WAIT;
        ST_WAIT: if (cip_rsp_valid) state <= ST_IDLE;
        ST_RD:   if (rd_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/keyreg_guard.sv
module keyreg_guard import kg_pkg::*; #(
  parameter int NREG     = 8,
  parameter int W        = 128,
  parameter int SW       = 6,
  parameter int AUTH_IDX = 6,
  localparam int IW      = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [IW-1:0]   cmd_dst,
  input  logic [IW-1:0]   cmd_src,
  input  logic [IW-1:0]   cmd_key,
  input  logic [SW-1:0]   cmd_sec,
  input  logic [W-1:0]    cmd_wdata,
  output logic [SW-1:0]   sec_idx,
  input  logic [W-1:0]    sec_data,
  output logic            cip_req_valid,
  input  logic            cip_req_ready,
  output logic [W-1:0]    cip_key,
  output logic [W-1:0]    cip_data,
  input  logic            cip_rsp_valid,
  output logic            cip_rsp_ready,
  input  logic [W-1:0]    cip_rsp_data,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [W-1:0]    rd_data,
  output logic            cmp_valid,
  output logic            cmp_pass,
  output logic            viol_flag,
  input  logic            viol_clr,
  output logic [NREG-1:0] conf_map
);
  kg_op_e        op;
  logic [W-1:0]  vals [NREG];
  logic          lbl_conf, wr_en, wr_conf, clr_all;
  logic [IW-1:0] wr_idx;
  logic [W-1:0]  wr_data;

  assign op      = kg_op_e'(cmd_op);
  assign sec_idx = cmd_sec;

  kg_label #(.SW(SW), .OPEN_SECRET(0)) u_label (
    .op(op), .sec(cmd_sec),
    .key_conf(conf_map[cmd_key]), .src_conf(conf_map[cmd_src]),
    .out_conf(lbl_conf)
  );

  kg_regbank #(.NREG(NREG), .W(W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_conf(wr_conf), .clr_all(clr_all),
    .vals(vals), .conf(conf_map)
  );

  kg_ctrl #(.NREG(NREG), .W(W), .AUTH_IDX(AUTH_IDX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .op(op), .cmd_dst(cmd_dst), .cmd_src(cmd_src), .cmd_key(cmd_key),
    .cmd_wdata(cmd_wdata), .sec_data(sec_data), .vals(vals), .conf(conf_map),
    .lbl_conf(lbl_conf), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_conf(wr_conf), .clr_all(clr_all),
    .cip_req_valid(cip_req_valid), .cip_req_ready(cip_req_ready),
    .cip_key(cip_key), .cip_data(cip_data), .cip_rsp_valid(cip_rsp_valid),
    .cip_rsp_ready(cip_rsp_ready), .cip_rsp_data(cip_rsp_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .cmp_valid(cmp_valid), .cmp_pass(cmp_pass),
    .viol_flag(viol_flag), .viol_clr(viol_clr)
  );
endmodule

// File: rtl/keyreg_guard_chk.sv
module keyreg_guard_chk #(
  parameter int NREG = 8,
  parameter int W    = 128,
  parameter int SW   = 6,
  localparam int IW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [2:0]      cmd_op,
  input logic [IW-1:0]   cmd_dst,
  input logic [IW-1:0]   cmd_src,
  input logic [SW-1:0]   cmd_sec,
  input logic            cip_req_valid,
  input logic            cip_req_ready,
  input logic [W-1:0]    cip_key,
  input logic [W-1:0]    cip_data,
  input logic            cip_rsp_ready,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [W-1:0]    rd_data,
  input logic            cmp_valid,
  input logic            viol_flag,
  input logic            viol_clr,
  input logic [NREG-1:0] conf_map
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  // R2
  load_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd0 |=> !conf_map[$past(cmd_dst)]);
  // R3
  secret_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd1 && cmd_sec == '0 |=> !conf_map[$past(cmd_dst)]);
  // R3
  secret_conf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd1 && cmd_sec != '0 |=> conf_map[$past(cmd_dst)]);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cip_req_valid && !cip_req_ready |=> cip_req_valid && $stable(cip_key) && $stable(cip_data));
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  // R7
  viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd4 && conf_map[cmd_src] |=> viol_flag && rd_data == '0);
  // R7
  viol_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag && !viol_clr |=> viol_flag);
  // R8
  cmp_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd5 |=> cmp_valid);
  // R9
  clear_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd6 |=> conf_map == '0);
  // R10
  busy_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cip_req_valid || cip_rsp_ready || rd_valid) |-> !cmd_ready);
endmodule

bind keyreg_guard keyreg_guard_chk #(.NREG(NREG), .W(W), .SW(SW)) u_chk (.*);

// File: tb/keyreg_guard_tb.sv
module keyreg_guard_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [2:0] cmd_op = 0, cmd_dst = 0, cmd_src = 0, cmd_key = 0;
  logic [5:0] cmd_sec = 0, sec_idx;
  logic [127:0] cmd_wdata = 0, sec_data, cip_key, cip_data, cip_rsp_data = 0, rd_data;
  logic cip_req_valid, cip_req_ready = 0, cip_rsp_valid = 0, cip_rsp_ready;
  logic rd_valid, rd_ready = 0, cmp_valid, cmp_pass, viol_flag, viol_clr = 0;
  logic [7:0] conf_map;

  int n_chk = 0, n_fail = 0;
  logic [127:0] mv [8];
  logic [7:0]   mc;
  logic         mviol;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [127:0] secret_fn(input logic [5:0] i);
    return {4{26'h2B5C3A1, i}};
  endfunction
  function automatic logic [127:0] cip_fn(input logic [127:0] k, input logic [127:0] d);
    return {k[63:0], k[127:64]} ^ d ^ 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
  endfunction
  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  assign sec_data = secret_fn(sec_idx);

  keyreg_guard u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [2:0] d, input logic [2:0] s,
                       input logic [2:0] k, input logic [5:0] sec, input logic [127:0] wd);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_dst = d; cmd_src = s; cmd_key = k;
    cmd_sec = sec; cmd_wdata = wd;
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic t_load(input logic [2:0] d, input logic [127:0] v);
    issue(3'd0, d, 0, 0, 0, v);
    mv[d] = v; mc[d] = 0;
    @(negedge clk);
    chk(conf_map == mc, "R2 load label", conf_map, mc);
  endtask

  task automatic t_secret(input logic [2:0] d, input logic [5:0] idx);
    issue(3'd1, d, 0, 0, idx, 0);
    mv[d] = secret_fn(idx); mc[d] = (idx != 0);
    @(negedge clk);
    chk(conf_map == mc, "R3 secret label", conf_map, mc);
  endtask

  task automatic t_enc(input bit sig, input logic [2:0] d, input logic [2:0] s,
                       input logic [2:0] k, input bit inject, input logic [2:0] inj_dst);
    logic [127:0] ek, ed, res;
    bit accepted, rdy;
    ek = mv[k]; ed = sig ? mv[6] : mv[s];
    issue(sig ? 3'd3 : 3'd2, d, s, k, 0, 0);
    accepted = 0;
    @(negedge clk);
    if (inject) begin
      cmd_valid = 1; cmd_op = 3'd0; cmd_dst = inj_dst; cmd_wdata = ~mv[inj_dst];
    end
    while (!accepted) begin
      chk(cip_req_valid && cip_key == ek, sig ? "R5 sig key" : "R4 enc key", cip_key, ek);
      chk(cip_data == ed, sig ? "R5 sig data" : "R4 enc data", cip_data, ed);
      chk(!cmd_ready, "R10 busy ready", {127'd0, cmd_ready}, 0);
      rdy = $urandom % 2;
      cip_req_ready = rdy;
      @(negedge clk);
      if (rdy) accepted = 1;
    end
    cip_req_ready = 0;
    cmd_valid = 0;
    repeat ($urandom % 3) @(negedge clk);
    chk(cip_rsp_ready, "R4 rsp ready", {127'd0, cip_rsp_ready}, 1);
    res = cip_fn(ek, ed);
    cip_rsp_valid = 1; cip_rsp_data = res;
    @(negedge clk);
    cip_rsp_valid = 0;
    mv[d] = res;
    mc[d] = sig ? 1'b0 : (mc[k] | mc[s]);
    chk(conf_map == mc, sig ? "R5 sig label" : "R4 enc label", conf_map, mc);
  endtask

  task automatic t_read(input logic [2:0] s, input int hold);
    logic [127:0] exp;
    exp = mc[s] ? 128'd0 : mv[s];
    issue(3'd4, 0, s, 0, 0, 0);
    if (mc[s]) mviol = 1;
    @(negedge clk);
    chk(rd_valid && rd_data == exp, mc[s] ? "R7 blocked data" : "R6 read data", rd_data, exp);
    chk(viol_flag == mviol, "R7 viol flag", {127'd0, viol_flag}, {127'd0, mviol});
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rd_valid && rd_data == exp, "R6 read hold", rd_data, exp);
    end
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
    chk(!rd_valid, "R6 read done", {127'd0, rd_valid}, 0);
  endtask

  task automatic t_cmp(input logic [2:0] a, input logic [2:0] b);
    logic expp;
    expp = (mv[a] == mv[b]);
    issue(3'd5, a, b, 0, 0, 0);
    @(negedge clk);
    chk(cmp_valid && cmp_pass == expp, "R8 compare", {126'd0, cmp_valid, cmp_pass}, {126'd0, 1'b1, expp});
    chk(conf_map == mc, "R8 labels unchanged", conf_map, mc);
    @(negedge clk);
    chk(!cmp_valid, "R8 one-cycle strobe", {127'd0, cmp_valid}, 0);
  endtask

  task automatic t_clear();
    issue(3'd6, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) mv[i] = 0;
    mc = 0;
    @(negedge clk);
    chk(conf_map == 0, "R9 clear labels", conf_map, 0);
  endtask

  task automatic t_vclr();
    @(negedge clk);
    viol_clr = 1;
    @(negedge clk);
    viol_clr = 0;
    mviol = 0;
    chk(!viol_flag, "R7 viol clear", {127'd0, viol_flag}, 0);
  endtask

  task automatic t_nop();
    issue(3'd7, $urandom % 8, $urandom % 8, $urandom % 8, $urandom % 64, rnd128());
    @(negedge clk);
    chk(conf_map == mc && viol_flag == mviol && cmd_ready, "R11 nop", {119'd0, viol_flag, conf_map}, {119'd0, mviol, mc});
  endtask

  function automatic logic [5:0] pick_sec();
    case ($urandom % 5)
      0: return 6'h00;
      1: return 6'h01;
      2: return 6'h26;
      3: return 6'h3f;
      default: return 6'($urandom % 64);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] mac, kk;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) mv[i] = 0;
    mc = 0; mviol = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready && conf_map == 0 && !viol_flag && !rd_valid && !cip_req_valid && !cmp_valid,
        "R1 reset state", {119'd0, viol_flag, conf_map}, 0);
    for (int i = 0; i < 8; i++) t_read(3'(i), 0);

    // authentication sequence
    mac = rnd128();
    t_load(7, 0);
    t_load(5, mac);
    t_secret(3, 6'h01);
    t_enc(0, 3, 7, 3, 0, 0);
    t_enc(0, 4, 5, 3, 1, 2);   // R10 injected load to r2 while busy
    kk = cip_fn(secret_fn(6'h01), 0);
    t_load(6, cip_fn(kk, mac));
    t_cmp(4, 6);
    t_read(4, 2);              // R7 blocked
    t_read(2, 0);              // R10 r2 still zero
    t_enc(0, 1, 6, 3, 0, 0);   // plain encrypt of known hash stays confidential
    t_enc(1, 2, 0, 3, 0, 0);   // R5 downgrade
    t_read(2, 3);
    t_vclr();
    t_secret(0, 6'h00);
    t_read(0, 1);
    t_nop();
    t_clear();
    t_read(3, 0);

    for (int it = 0; it < 300; it++) begin
      case ($urandom % 10)
        0: t_load($urandom % 8, rnd128());
        1: t_secret($urandom % 8, pick_sec());
        2, 3: t_enc(0, $urandom % 8, $urandom % 8, $urandom % 8, $urandom % 2, $urandom % 8);
        4: t_enc(1, $urandom % 8, $urandom % 8, $urandom % 8, 0, 0);
        5: t_read($urandom % 8, $urandom % 3);
        6: begin
          logic [2:0] a;
          a = $urandom % 8;
          t_cmp(a, ($urandom % 3 == 0) ? a : 3'($urandom % 8));
        end
        7: if ($urandom % 4 == 0) t_clear(); else t_load($urandom % 8, rnd128());
        8: t_vclr();
        default: t_nop();
      endcase
    end
    for (int i = 0; i < 8; i++) t_read(3'(i), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule